// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

This block governs what a processor does between the end of reset and its first instruction fetch. While reset is held it captures a four-bit strap code. Three bits come from dedicated strap inputs. The fourth is read from a pin that doubles as a general-purpose flag. When reset is released, that pin is handed back to the flag logic: its output enable and its input path reach the core again. Also during reset, the block forces the stack pointers to empty, masks every interrupt and clears the mode-status register.

After release the captured code selects one of three start-up paths:

- **Byte-memory copy.** A fixed number of program words is copied from a byte-wide boot memory. Each word is assembled from consecutive bytes fetched over a request/ready read port. The words are written into program memory one strobe per word.
- **Host wait.** The block waits until a host writes internal program address zero.
- **No boot.** Fetch is released at once from external memory.

A copy or a host wait starts only once no external bus request is pending. Fetch stays held until the chosen condition is met. It is then released at the proper start address, and a one-cycle completion pulse is raised. The block also reports whether host mode is selected and whether the host acknowledge line must be actively driven.

Top module: `boot_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, every bit of `sp_force_empty` and `irq_mask_all` is 1 and `mstat_clear` is 1. After release they are all 0, `fetch_en` is 0 and `boot_done` is 0.
- R2: The strap code is {`strap_sel3`, `pf_pin_in`, `strap_sel1`, `strap_sel0`} (bit 3 down to bit 0). It is taken on clock edges while `rst_n` is low, and strap changes after release have no effect.
  - While `rst_n` is low, `pf_pin_oe` is 0 and `core_flag_in` is 0.
  - After release, `pf_pin_oe` follows `core_flag_oe` and `core_flag_in` follows `pf_pin_in`.
- R3: Codes 0000 and 1000 copy 32 words from byte memory with `host_mode` = 0.
- R4: Codes 0010 and 1010, and every code not named in R3, R5 or R6, select no boot.
  - `br_req` and `pm_we` are never raised.
  - `fetch_ext` is 1 and `host_mode` is 0.
  - `fetch_en` rises one clock edge after release.
- R5: Codes 0100 and 1100 perform the same 32-word copy with `host_mode` = 1.
- R6: Codes 0101 and 1101 set `host_mode` = 1 and hold fetch until a cycle with `host_wr` = 1 and `host_addr` = 0. A host write to any other address leaves fetch held.
- R7: While `bus_req` is 1 after release, neither a copy nor a host wait begins (`br_req` stays 0). The boot starts after `bus_req` returns to 0.
- R8: After a copy or host-wait boot, fetch is released with `fetch_ext` = 0 and `fetch_addr` = 0.
- R9: `ack_drive_en` is 1 only in host mode with strap bit 3 = 0. In host mode with bit 3 = 1, and in non-host modes, it is 0.
- R10: Byte handshakes complete on cycles with `br_req` and `br_rdy` both 1.
  - `br_addr` starts at 0 and rises by one per completed byte, so it reads 96 after a full copy.
  - Each 24-bit word is built from three bytes, the first byte read landing in bits 23:16.
- R11: Each assembled word is written with a single-cycle `pm_we`, `pm_addr` equal to the word index. Exactly 32 strobes occur per copy.
- R12: `boot_done` is a single-cycle pulse raised once per boot, in the first cycle `fetch_en` is 1. `fetch_en` then stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampling window |
| strap_sel0 | input | 1 | Strap code bit 0 |
| strap_sel1 | input | 1 | Strap code bit 1 |
| strap_sel3 | input | 1 | Strap code bit 3 (acknowledge drive select) |
| pf_pin_in | input | 1 | Shared pin input value; strap bit 2 during reset |
| pf_pin_out | output | 1 | Shared pin output value from the flag logic |
| pf_pin_oe | output | 1 | Shared pin output enable |
| core_flag_out | input | 1 | Flag value the core wants to drive |
| core_flag_oe | input | 1 | Core request to drive the flag pin |
| core_flag_in | output | 1 | Flag input value seen by the core |
| bus_req | input | 1 | External bus request pending |
| br_req | output | 1 | Boot byte read request |
| br_addr | output | BADDR_W | Boot byte address |
| br_data | input | BYTE_W | Boot byte read data |
| br_rdy | input | 1 | Byte read completes this cycle |
| pm_we | output | 1 | Program memory write strobe |
| pm_addr | output | PADDR_W | Program memory write address |
| pm_wdata | output | WORD_W | Program memory write data |
| host_wr | input | 1 | Host write to internal program memory |
| host_addr | input | PADDR_W | Host write address |
| fetch_en | output | 1 | Instruction fetch released |
| fetch_ext | output | 1 | Start address lies in external memory |
| fetch_addr | output | PADDR_W | First fetch address |
| boot_done | output | 1 | One-cycle pulse when fetch is released |
| host_mode | output | 1 | Host mode selected |
| ack_drive_en | output | 1 | Acknowledge line actively driven |
| sp_force_empty | output | SP_COUNT | Per-stack force-empty |
| irq_mask_all | output | IRQ_W | Per-interrupt forced mask |
| mstat_clear | output | 1 | Mode-status register clear |

## Verification
All sixteen strap codes are run through a table. Each entry is booted to completion and its mode flag, start location and acknowledge drive are compared. Together these separate the byte copy, the host wait and no-boot paths, as well as the two host-mode acknowledge variants. Every other entry stalls `br_rdy` on a repeating pattern, which shows that word assembly, the byte address and the write strobes follow completed handshakes rather than cycles. Host-wait entries first write a nonzero address to show it does not release fetch. Directed runs hold `bus_req` across release to show the boot is deferred, and check the reset-time forcing and shared-pin handover.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   typedef enum logic [1:0] {
      BK_BYTE = 2'd0,
      BK_HOST = 2'd1,
      BK_NONE = 2'd2
   } boot_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_HOST = 2'd2,
      ST_RUN  = 2'd3
   } seq_state_e;

   typedef struct packed {
      boot_kind_e kind;
      logic       host_mode;
      logic       ext_start;
      logic       ack_drive;
   } boot_cfg_t;

   localparam int STRAP_W = 4;

endpackage

// File: rtl/boot_mode_decode.sv
module boot_mode_decode
   import boot_seq_pkg::*;
(
   input  logic [STRAP_W-1:0] code,
   output boot_cfg_t          cfg
);
   // code bit 2 selects host mode, bit 3 picks passive acknowledge
   always_comb begin
      cfg = '{kind: BK_NONE, host_mode: 1'b0, ext_start: 1'b1, ack_drive: 1'b0};
      casez (code)
         4'b?000: begin
            cfg.kind      = BK_BYTE;
            cfg.ext_start = 1'b0;
         end
         4'b?100: begin
            cfg.kind      = BK_BYTE;
            cfg.host_mode = 1'b1;
            cfg.ext_start = 1'b0;
            cfg.ack_drive = ~code[3];
         end
         4'b?101: begin
            cfg.kind      = BK_HOST;
            cfg.host_mode = 1'b1;
            cfg.ext_start = 1'b0;
            cfg.ack_drive = ~code[3];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/boot_byte_loader.sv
module boot_byte_loader #(
   parameter int WORD_W     = 24,
   parameter int BYTE_W     = 8,
   parameter int BOOT_WORDS = 32,
   parameter int BADDR_W    = 16,
   parameter int PADDR_W    = 14,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   output logic               br_req,
   output logic [BADDR_W-1:0] br_addr,
   input  logic [BYTE_W-1:0]  br_data,
   input  logic               br_rdy,
   output logic               pm_we,
   output logic [PADDR_W-1:0] pm_addr,
   output logic [WORD_W-1:0]  pm_wdata,
   output logic               done
);
   localparam int BPW    = WORD_W / BYTE_W;
   localparam int ASM_W  = WORD_W - BYTE_W;
   localparam int BIDX_W = (BPW > 2) ? $clog2(BPW) : 1;
   localparam int WCNT_W = $clog2(BOOT_WORDS);
   localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(BPW - 1);
   localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(BOOT_WORDS - 1);

   logic [BADDR_W-1:0] addr_q;
   logic [BIDX_W-1:0]  bidx_q;
   logic [WCNT_W-1:0]  wcnt_q;
   logic [ASM_W-1:0]   asm_q;
   logic [WORD_W-1:0]  asm_nx;
   logic [ASM_W-1:0]   asm_keep;
   logic               we_q;
   logic [PADDR_W-1:0] waddr_q;
   logic [WORD_W-1:0]  wdata_q;
   logic               fin_q;
   logic               hs;

   // byte order variant
   generate
      if (MSB_FIRST) begin : g_msb_first
         assign asm_nx   = {asm_q, br_data};
         assign asm_keep = asm_nx[ASM_W-1:0];
      end else begin : g_lsb_first
         assign asm_nx   = {br_data, asm_q};
         assign asm_keep = asm_nx[WORD_W-1:BYTE_W];
      end
   endgenerate

   assign br_req = run & ~fin_q;
   assign hs     = br_req & br_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         bidx_q  <= '0;
         wcnt_q  <= '0;
         asm_q   <= '0;
         we_q    <= 1'b0;
         waddr_q <= '0;
         wdata_q <= '0;
         fin_q   <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (hs) begin
            addr_q <= addr_q + 1'b1;
            if (bidx_q == BIDX_LAST) begin
               bidx_q  <= '0;
               we_q    <= 1'b1;
               wdata_q <= asm_nx;
               waddr_q <= PADDR_W'(wcnt_q);
               wcnt_q  <= wcnt_q + 1'b1;
               if (wcnt_q == WCNT_LAST) fin_q <= 1'b1;
            end else begin
               bidx_q <= bidx_q + 1'b1;
               asm_q  <= asm_keep;
            end
         end
      end
   end

   assign br_addr  = addr_q;
   assign pm_we    = we_q;
   assign pm_addr  = waddr_q;
   assign pm_wdata = wdata_q;
   assign done     = fin_q;
endmodule

// File: rtl/boot_host_watch.sv
module boot_host_watch #(
   parameter int PADDR_W = 14
) (
   input  logic               armed,
   input  logic               host_wr,
   input  logic [PADDR_W-1:0] host_addr,
   output logic               hit
);
   assign hit = armed & host_wr & (host_addr == '0);
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
   import boot_seq_pkg::*;
#(
   parameter int WORD_W     = 24,
   parameter int BYTE_W     = 8,
   parameter int BOOT_WORDS = 32,
   parameter int BADDR_W    = 16,
   parameter int PADDR_W    = 14,
   parameter int SP_COUNT   = 4,
   parameter int IRQ_W      = 12,
   parameter bit MSB_FIRST  = 1'b1,
   parameter int INT_START  = 0,
   parameter int EXT_START  = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                strap_sel0,
   input  logic                strap_sel1,
   input  logic                strap_sel3,
   input  logic                pf_pin_in,
   output logic                pf_pin_out,
   output logic                pf_pin_oe,
   input  logic                core_flag_out,
   input  logic                core_flag_oe,
   output logic                core_flag_in,
   input  logic                bus_req,
   output logic                br_req,
   output logic [BADDR_W-1:0]  br_addr,
   input  logic [BYTE_W-1:0]   br_data,
   input  logic                br_rdy,
   output logic                pm_we,
   output logic [PADDR_W-1:0]  pm_addr,
   output logic [WORD_W-1:0]   pm_wdata,
   input  logic                host_wr,
   input  logic [PADDR_W-1:0]  host_addr,
   output logic                fetch_en,
   output logic                fetch_ext,
   output logic [PADDR_W-1:0]  fetch_addr,
   output logic                boot_done,
   output logic                host_mode,
   output logic                ack_drive_en,
   output logic [SP_COUNT-1:0] sp_force_empty,
   output logic [IRQ_W-1:0]    irq_mask_all,
   output logic                mstat_clear
);
   localparam int BPW = WORD_W / BYTE_W;
   localparam logic [PADDR_W-1:0] INT_PC = PADDR_W'(INT_START);
   localparam logic [PADDR_W-1:0] EXT_PC = PADDR_W'(EXT_START);

   // elaboration checks
   generate
      if (WORD_W % BYTE_W != 0 || BPW < 2) begin : g_bad_width
         $error("WORD_W must be a multiple of BYTE_W, at least two bytes");
      end
      if (BOOT_WORDS < 2 || (2 ** PADDR_W) < BOOT_WORDS) begin : g_bad_words
         $error("BOOT_WORDS must be >= 2 and fit in PADDR_W");
      end
      if ((2 ** BADDR_W) < BOOT_WORDS * BPW) begin : g_bad_baddr
         $error("BADDR_W too narrow for the boot image");
      end
      if (SP_COUNT < 1 || IRQ_W < 1) begin : g_bad_counts
         $error("SP_COUNT and IRQ_W must be positive");
      end
   endgenerate

   logic                in_reset;
   logic [STRAP_W-1:0]  strap_q;
   boot_cfg_t           cfg;
   seq_state_e          st_q, st_nx;
   logic                done_q;
   logic                ld_done;
   logic                host_hit;

   assign in_reset = ~rst_n;

   // strap capture window is the reset period only
   always_ff @(posedge clk) begin
      if (in_reset) strap_q <= {strap_sel3, pf_pin_in, strap_sel1, strap_sel0};
   end

   // shared pin goes back to the flag logic once reset ends
   assign pf_pin_out   = core_flag_out;
   assign pf_pin_oe    = core_flag_oe & rst_n;
   assign core_flag_in = pf_pin_in & rst_n;

   // reset-time forcing of core state
   generate
      for (genvar s = 0; s < SP_COUNT; s++) begin : g_sp
         assign sp_force_empty[s] = in_reset;
      end
      for (genvar q = 0; q < IRQ_W; q++) begin : g_irq
         assign irq_mask_all[q] = in_reset;
      end
   endgenerate
   assign mstat_clear = in_reset;

   boot_mode_decode u_decode (
      .code (strap_q),
      .cfg  (cfg)
   );

   boot_byte_loader #(
      .WORD_W     (WORD_W),
      .BYTE_W     (BYTE_W),
      .BOOT_WORDS (BOOT_WORDS),
      .BADDR_W    (BADDR_W),
      .PADDR_W    (PADDR_W),
      .MSB_FIRST  (MSB_FIRST)
   ) u_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (st_q == ST_LOAD),
      .br_req   (br_req),
      .br_addr  (br_addr),
      .br_data  (br_data),
      .br_rdy   (br_rdy),
      .pm_we    (pm_we),
      .pm_addr  (pm_addr),
      .pm_wdata (pm_wdata),
      .done     (ld_done)
   );

   boot_host_watch #(
      .PADDR_W (PADDR_W)
   ) u_host (
      .armed     (st_q == ST_HOST),
      .host_wr   (host_wr),
      .host_addr (host_addr),
      .hit       (host_hit)
   );

   always_comb begin
      st_nx = st_q;
      case (st_q)
         ST_IDLE: begin
            if (cfg.kind == BK_NONE)     st_nx = ST_RUN;
            else if (!bus_req)           st_nx = (cfg.kind == BK_BYTE) ? ST_LOAD : ST_HOST;
         end
         ST_LOAD: if (ld_done)  st_nx = ST_RUN;
         ST_HOST: if (host_hit) st_nx = ST_RUN;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (in_reset) begin
         st_q   <= ST_IDLE;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_nx;
         done_q <= (st_q != ST_RUN) && (st_nx == ST_RUN);
      end
   end

   assign fetch_en     = (st_q == ST_RUN);
   assign boot_done    = done_q;
   assign fetch_ext    = cfg.ext_start;
   assign fetch_addr   = cfg.ext_start ? EXT_PC : INT_PC;
   assign host_mode    = cfg.host_mode;
   assign ack_drive_en = cfg.ack_drive;
endmodule

// File: rtl/boot_seq_ctrl_chk.sv
module boot_seq_ctrl_chk #(
   parameter int SP_COUNT = 4,
   parameter int IRQ_W    = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                pf_pin_oe,
   input logic                core_flag_in,
   input logic                bus_req,
   input logic                br_req,
   input logic                pm_we,
   input logic                fetch_en,
   input logic                fetch_ext,
   input logic                boot_done,
   input logic                host_mode,
   input logic                ack_drive_en,
   input logic [SP_COUNT-1:0] sp_force_empty,
   input logic [IRQ_W-1:0]    irq_mask_all,
   input logic                mstat_clear
);
   always @(negedge clk) begin
      if (rst_n === 1'b0) begin
         assert_reset_force_R1: assert (&sp_force_empty && &irq_mask_all && mstat_clear)
            else $error("core state not forced during reset");
         assert_pin_released_R2: assert (!pf_pin_oe && !core_flag_in)
            else $error("shared pin used as flag during reset");
      end
   end

   assert_no_boot_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ext |-> !br_req);

   assert_bus_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(br_req) |-> !$past(bus_req));

   assert_ack_host_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_drive_en |-> host_mode);

   assert_we_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pm_we |=> !pm_we);

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> !boot_done);

   assert_done_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |-> fetch_en);

   assert_fetch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_en |=> fetch_en);
endmodule

bind boot_seq_ctrl boot_seq_ctrl_chk #(
   .SP_COUNT (SP_COUNT),
   .IRQ_W    (IRQ_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pf_pin_oe      (pf_pin_oe),
   .core_flag_in   (core_flag_in),
   .bus_req        (bus_req),
   .br_req         (br_req),
   .pm_we          (pm_we),
   .fetch_en       (fetch_en),
   .fetch_ext      (fetch_ext),
   .boot_done      (boot_done),
   .host_mode      (host_mode),
   .ack_drive_en   (ack_drive_en),
   .sp_force_empty (sp_force_empty),
   .irq_mask_all   (irq_mask_all),
   .mstat_clear    (mstat_clear)
);

// File: tb/boot_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module boot_seq_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SP_COUNT   = 4;
   localparam int IRQ_W      = 12;

   // {code[3:0], kind[1:0] (0 copy,1 host wait,2 none), host, ext, ack}
   localparam logic [8:0] VEC [16] = '{
      {4'b0000, 2'd0, 1'b0, 1'b0, 1'b0},
      {4'b0001, 2'd2, 1'b0, 1'b1, 1'b0},
      {4'b0010, 2'd2, 1'b0, 1'b1, 1'b0},
      {4'b0011, 2'd2, 1'b0, 1'b1, 1'b0},
      {4'b0100, 2'd0, 1'b1, 1'b0, 1'b1},
      {4'b0101, 2'd1, 1'b1, 1'b0, 1'b1},
      {4'b0110, 2'd2, 1'b0, 1'b1, 1'b0},
      {4'b0111, 2'd2, 1'b0, 1'b1, 1'b0},
      {4'b1000, 2'd0, 1'b0, 1'b0, 1'b0},
      {4'b1001, 2'd2, 1'b0, 1'b1, 1'b0},
      {4'b1010, 2'd2, 1'b0, 1'b1, 1'b0},
      {4'b1011, 2'd2, 1'b0, 1'b1, 1'b0},
      {4'b1100, 2'd0, 1'b1, 1'b0, 1'b0},
      {4'b1101, 2'd1, 1'b1, 1'b0, 1'b0},
      {4'b1110, 2'd2, 1'b0, 1'b1, 1'b0},
      {4'b1111, 2'd2, 1'b0, 1'b1, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_sel0 = 1'b0, strap_sel1 = 1'b0, strap_sel3 = 1'b0;
   logic        pf_pin_in = 1'b0;
   logic        core_flag_out = 1'b0, core_flag_oe = 1'b0;
   logic        bus_req = 1'b0;
   logic        br_rdy = 1'b1;
   logic        host_wr = 1'b0;
   logic [13:0] host_addr = '0;
   logic        pf_pin_out, pf_pin_oe, core_flag_in, br_req, pm_we;
   logic [15:0] br_addr;
   logic [7:0]  br_data;
   logic [13:0] pm_addr, fetch_addr;
   logic [23:0] pm_wdata;
   logic        fetch_en, fetch_ext, boot_done, host_mode, ack_drive_en, mstat_clear;
   logic [SP_COUNT-1:0] sp_force_empty;
   logic [IRQ_W-1:0]    irq_mask_all;

   int   total = 0, bad = 0;
   bit   finished = 1'b0;
   bit   stall = 1'b0;
   int   rdy_phase = 0;
   int   wr_cnt = 0, done_cnt = 0, req_cnt = 0, done_nofetch = 0;
   logic [23:0] cap [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] bmem(input logic [15:0] a);
      logic [15:0] t;
      t = a * 16'd29 + 16'd7;
      return t[7:0] ^ a[10:3];
   endfunction

   assign br_data = bmem(br_addr);

   boot_seq_ctrl #(.SP_COUNT(SP_COUNT), .IRQ_W(IRQ_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_sel0(strap_sel0), .strap_sel1(strap_sel1),
      .strap_sel3(strap_sel3), .pf_pin_in(pf_pin_in), .pf_pin_out(pf_pin_out),
      .pf_pin_oe(pf_pin_oe), .core_flag_out(core_flag_out), .core_flag_oe(core_flag_oe),
      .core_flag_in(core_flag_in), .bus_req(bus_req), .br_req(br_req), .br_addr(br_addr),
      .br_data(br_data), .br_rdy(br_rdy), .pm_we(pm_we), .pm_addr(pm_addr),
      .pm_wdata(pm_wdata), .host_wr(host_wr), .host_addr(host_addr), .fetch_en(fetch_en),
      .fetch_ext(fetch_ext), .fetch_addr(fetch_addr), .boot_done(boot_done),
      .host_mode(host_mode), .ack_drive_en(ack_drive_en), .sp_force_empty(sp_force_empty),
      .irq_mask_all(irq_mask_all), .mstat_clear(mstat_clear)
   );

   // ready pattern, changed away from the active edge
   initial forever begin
      @(negedge clk);
      rdy_phase++;
      br_rdy = stall ? (rdy_phase % 3 != 1) : 1'b1;
   end

   // observe write strobes, requests and completion pulses
   always @(negedge clk) begin
      if (rst_n) begin
         if (pm_we) begin
            if (pm_addr < 14'd32) cap[pm_addr[4:0]] = pm_wdata;
            wr_cnt++;
         end
         if (br_req) req_cnt++;
         if (boot_done) begin
            done_cnt++;
            if (!fetch_en) done_nofetch++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_straps(input logic [3:0] c);
      strap_sel0 = c[0];
      strap_sel1 = c[1];
      pf_pin_in  = c[2];
      strap_sel3 = c[3];
   endtask

   task automatic enter_reset(input logic [3:0] c);
      rst_n = 1'b0;
      set_straps(c);
      repeat (3) @(posedge clk);
      @(negedge clk);
      wr_cnt = 0; done_cnt = 0; req_cnt = 0; done_nofetch = 0;
      for (int i = 0; i < 32; i++) cap[i] = '0;
   endtask

   task automatic check_image(input string req);
      int miss;
      miss = 0;
      for (int w = 0; w < 32; w++) begin
         logic [15:0] b;
         b = 16'(3 * w);
         if (cap[w] !== {bmem(b), bmem(b + 16'd1), bmem(b + 16'd2)}) miss++;
      end
      chk(miss == 0, req, miss, 0);
   endtask

   task automatic run_vec(input logic [8:0] v, input int idx);
      logic [3:0] code;
      logic [1:0] kind;
      int after;
      code = v[8:5];
      kind = v[4:3];
      stall = (idx % 2 == 1);
      enter_reset(code);
      rst_n = 1'b1;
      set_straps(~code);
      after = 0;
      for (int c = 0; c < 800 && after < 4; c++) begin
         @(negedge clk);
         if (kind == 2'd1) begin
            if (c == 4) begin host_wr = 1'b1; host_addr = 14'd5; end
            if (c == 5) host_wr = 1'b0;
            if (c == 8) chk(!fetch_en, "R6 nonzero host write released fetch", int'(fetch_en), 0);
            if (c == 9) begin host_wr = 1'b1; host_addr = 14'd0; end
            if (c == 10) host_wr = 1'b0;
         end
         if (kind == 2'd2 && c == 0)
            chk(fetch_en && boot_done, "R4 no-boot fetch one edge after release", int'(fetch_en), 1);
         if (fetch_en) after++;
      end
      chk(fetch_en, "R12 fetch released", int'(fetch_en), 1);
      chk(done_cnt == 1 && done_nofetch == 0, "R12 single done pulse with fetch", done_cnt, 1);
      chk(host_mode == v[2], (kind == 2'd1) ? "R6 host flag" : (v[2] ? "R5 host flag" : "R3 R4 host flag"),
          int'(host_mode), int'(v[2]));
      chk(fetch_ext == v[1], v[1] ? "R4 external start" : "R8 internal start", int'(fetch_ext), int'(v[1]));
      chk(fetch_addr == 14'd0, "R8 start address", int'(fetch_addr), 0);
      chk(ack_drive_en == v[0], "R9 acknowledge drive", int'(ack_drive_en), int'(v[0]));
      chk(core_flag_in == pf_pin_in, "R2 flag input after release", int'(core_flag_in), int'(pf_pin_in));
      if (kind == 2'd0) begin
         chk(wr_cnt == 32, "R11 write strobe count", wr_cnt, 32);
         chk(br_addr == 16'd96, "R10 final byte address", int'(br_addr), 96);
         check_image(v[2] ? "R5 R10 copied image" : "R3 R10 copied image");
         chk(!br_req, "R3 requests stop after copy", int'(br_req), 0);
      end else begin
         chk(wr_cnt == 0 && req_cnt == 0, "R4 R6 no byte traffic", wr_cnt + req_cnt, 0);
      end
   endtask

   initial begin
      // reset state, R1 and R2
      core_flag_oe = 1'b1;
      enter_reset(4'b0010);
      pf_pin_in = 1'b1;
      #1;
      chk(&sp_force_empty && &irq_mask_all && mstat_clear, "R1 reset forcing", int'(mstat_clear), 1);
      chk(!fetch_en && !boot_done, "R1 fetch held in reset", int'(fetch_en), 0);
      chk(!pf_pin_oe && !core_flag_in, "R2 pin held off flag use in reset", int'(pf_pin_oe), 0);
      enter_reset(4'b0010);
      rst_n = 1'b1;
      #1;
      chk(pf_pin_oe == 1'b1, "R2 pin output enable follows core", int'(pf_pin_oe), 1);
      chk(sp_force_empty == '0 && irq_mask_all == '0 && !mstat_clear, "R1 forcing released",
          int'(sp_force_empty), 0);
      core_flag_oe = 1'b0;
      @(negedge clk);
      chk(pf_pin_oe == 1'b0, "R2 pin output enable off", int'(pf_pin_oe), 0);

      // table of all strap codes
      for (int i = 0; i < 16; i++) run_vec(VEC[i], i);
      stall = 1'b0;

      // pending bus request defers the copy, R7
      enter_reset(4'b0000);
      bus_req = 1'b1;
      rst_n = 1'b1;
      repeat (12) @(negedge clk);
      chk(req_cnt == 0 && !fetch_en, "R7 copy deferred while bus requested", req_cnt, 0);
      bus_req = 1'b0;
      repeat (130) @(negedge clk);
      chk(wr_cnt == 32 && fetch_en, "R7 copy runs after bus request clears", wr_cnt, 32);
      check_image("R7 R10 image after deferral");

      // host wait also deferred by bus request, R7
      enter_reset(4'b0101);
      bus_req = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      host_wr = 1'b1; host_addr = 14'd0;
      @(negedge clk);
      host_wr = 1'b0;
      repeat (3) @(negedge clk);
      chk(!fetch_en, "R7 host write ignored while bus requested", int'(fetch_en), 0);
      bus_req = 1'b0;
      repeat (2) @(negedge clk);
      host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
      chk(fetch_en && !fetch_ext, "R6 host write to zero releases fetch", int'(fetch_en), 1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule